// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Generator

This block drives the frequency-offset input of a fractional-N feedback divider so that a synthesized clock sweeps slowly around its nominal frequency and spreads its energy over a band. Each clock it produces one signed offset word, scaled so that one LSB is 1/65536 of the nominal frequency. The word follows a linear triangle: it climbs from the lowest frequency of the sweep to the highest and then returns. One such return trip is a modulation period.

Two spreading styles are available. Center spread swings equally above and below nominal, so the mean frequency is unchanged. Down spread places the top of the triangle exactly on nominal and hangs the whole sweep below it, so no instant exceeds the nominal rate. The depth is a code in 0.125 % steps. The sweep period is one of two lengths, which correspond to roughly 30 kHz and 120 kHz at a 61.44 MHz sample clock. A one-cycle flag marks each visit to the bottom of the sweep. New settings are picked up only at that bottom point or while the block is disabled, so a running sweep never tears mid-slope.

Top module: `ssc_tri_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `offset` becomes 0 and `cycle_flag` becomes 0.
- R2: A clock edge with `en` low makes `offset` 0 and `cycle_flag` 0 and parks the internal phase at the midpoint of its range, rising. After `en` goes high, the first edge that sees it produces the profile value for phase H/2+1.
- R3: In center mode (`mode_down`=0) the output is `((2A*p) >> log2(H)) - A`. Here p is the phase (0..H) and A is the amplitude, so the output spans -A..+A and the peak is at p=H.
- R4: In down mode (`mode_down`=1) the output is `((2A*p) >> log2(H)) - 2A`. It never exceeds 0, reaches 0 at p=H and reaches -2A at p=0.
- R5: The amplitude is A = k*82 LSB, where k is `dev_code` clamped to 16 (codes 17..31 act as 16). Code 0 gives a flat zero output.
- R6: `rate_fast`=1 selects H=256 (period 512 clocks). `rate_fast`=0 selects H=1024 (period 2048 clocks).
- R7: `cycle_flag` is high for exactly one clock, in the cycle in which `offset` shows the sweep minimum (p=0). From enable it first rises after 3H/2 edges, and after that once every 2H edges.
- R8: Changes to `mode_down`, `rate_fast` and `dev_code` while enabled take effect only from the edge that brings the sweep to its minimum. Edges before that one keep the old settings.
- R9: With unchanged settings, two consecutive outputs differ by no more than 11 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run the sweep; low holds the output at zero |
| mode_down | input | 1 | 0 = center spread, 1 = down spread |
| rate_fast | input | 1 | 0 = long period (2048 clocks), 1 = short period (512 clocks) |
| dev_code | input | 5 | Depth code k in 0.125 % steps, clamped to 16 |
| offset | output | 16 | Signed frequency offset, LSB = nominal/65536 |
| cycle_flag | output | 1 | One-cycle pulse at each sweep minimum |

## Verification
The bench checks the turning points of the sweep. At the top, a design that mishandles the reversal holds or overshoots the peak and so misses A, or 0 in down mode. At the bottom, an off-by-one in the reversal moves the flag one edge early or late, or lengthens the pulse. It compares the two periods against 512 and 2048 clocks and checks that depth codes above 16 clamp, so a design that wraps those codes shows a small or odd amplitude. It also changes settings in the middle of a slope and checks that the old values hold until the minimum. A design that loads settings right away shows a jump at the next peak. Re-enabling must restart from the midpoint, so a counter that resumes from its old phase gives the wrong first sample.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
// ssc_pkg: shared encodings for the spread-spectrum offset generator.
// Assumes: one bit each for spread style and sweep rate.
package ssc_pkg;
    typedef enum logic {SPREAD_CENTER = 1'b0, SPREAD_DOWN = 1'b1} spread_mode_e;
    typedef enum logic {RATE_SLOW = 1'b0, RATE_FAST = 1'b1} mod_rate_e;
endpackage

// File: rtl/ssc_cfg_reg.sv
`timescale 1ns/1ps
// ssc_cfg_reg: holds the active sweep settings and turns the depth code
// into an amplitude in offset LSBs.
// Assumes: load is high while disabled and at each sweep minimum.
module ssc_cfg_reg import ssc_pkg::*; #(
    parameter int DEV_W    = 5,
    parameter int DEV_MAX  = 16,
    parameter int STEP_LSB = 82,
    parameter int AMP_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             mode_down,
    input  logic             rate_fast,
    input  logic [DEV_W-1:0] dev_code,
    output spread_mode_e     mode_q,
    output mod_rate_e        rate_q,
    output logic [AMP_W-1:0] amp_q
);
    logic [DEV_W-1:0] dev_eff;
    logic [AMP_W-1:0] amp_n;

    // Clamp the depth code and scale it into an amplitude.
    always_comb begin
        if ({1'b0, dev_code} > (DEV_W+1)'(DEV_MAX))
            dev_eff = DEV_W'(DEV_MAX);
        else
            dev_eff = dev_code;
        amp_n = AMP_W'(dev_eff) * AMP_W'(STEP_LSB);
    end

    // Capture the settings on load, otherwise hold them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SPREAD_CENTER;
            rate_q <= RATE_SLOW;
            amp_q  <= '0;
        end else if (load) begin
            mode_q <= mode_down ? SPREAD_DOWN : SPREAD_CENTER;
            rate_q <= rate_fast ? RATE_FAST : RATE_SLOW;
            amp_q  <= amp_n;
        end
    end
endmodule

// File: rtl/ssc_phase_ctr.sv
`timescale 1ns/1ps
// ssc_phase_ctr: up/down phase counter that walks 0..H..0 one step per clock.
// Assumes: H is a power of two picked by fast_sel; the counter parks at H/2,
// rising, whenever run is low.
module ssc_phase_ctr #(
    parameter int HL_FAST = 8,
    parameter int HL_SLOW = 10,
    parameter int PW      = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          fast_sel,
    output logic [PW-1:0] phase_nxt,
    output logic          wrap_nxt
);
    localparam logic [PW-1:0] ONE    = {{(PW-1){1'b0}}, 1'b1};
    localparam logic [PW-1:0] HALF_F = ONE << HL_FAST;
    localparam logic [PW-1:0] HALF_S = ONE << HL_SLOW;

    logic [PW-1:0] phase_q;
    logic          up_q;
    logic          up_nxt;
    logic [PW-1:0] half;
    logic [PW-1:0] mid;

    assign half = fast_sel ? HALF_F : HALF_S;
    assign mid  = half >> 1;

    // Next phase and direction; reverse on reaching either end.
    always_comb begin
        if (up_q) begin
            phase_nxt = phase_q + ONE;
            up_nxt    = (phase_nxt != half);
        end else begin
            phase_nxt = phase_q - ONE;
            up_nxt    = (phase_q == ONE);
        end
        wrap_nxt = run && !up_q && (phase_q == ONE);
    end

    // Advance while running, park at the midpoint otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= HALF_S >> 1;
            up_q    <= 1'b1;
        end else if (!run) begin
            phase_q <= mid;
            up_q    <= 1'b1;
        end else begin
            phase_q <= phase_nxt;
            up_q    <= up_nxt;
        end
    end
endmodule

// File: rtl/ssc_shaper.sv
`timescale 1ns/1ps
// ssc_shaper: maps phase and amplitude to the signed offset word and registers it.
// Assumes: phase lies in 0..H, so the scaled ramp never exceeds 2*amp.
module ssc_shaper import ssc_pkg::*; #(
    parameter int AMP_W   = 11,
    parameter int PW      = 11,
    parameter int OFS_W   = 16,
    parameter int HL_FAST = 8,
    parameter int HL_SLOW = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [PW-1:0]           phase_nxt,
    input  logic [AMP_W-1:0]        amp,
    input  spread_mode_e            mode,
    input  mod_rate_e               rate,
    output logic signed [OFS_W-1:0] offset_q
);
    localparam int PROD_W = AMP_W + 1 + PW;

    logic [AMP_W:0]           span;
    logic [PROD_W-1:0]        prod;
    logic [AMP_W:0]           ramp;
    logic signed [OFS_W-1:0]  ramp_s;
    logic signed [OFS_W-1:0]  base_s;
    logic signed [OFS_W-1:0]  off_n;

    assign span = {amp, 1'b0};
    assign prod = PROD_W'(span) * PROD_W'(phase_nxt);

    // Divide by H: a fixed shift when both rates match, a mux otherwise.
    generate
        if (HL_FAST == HL_SLOW) begin : g_one_rate
            assign ramp = (AMP_W+1)'(prod >> HL_FAST);
        end else begin : g_two_rates
            assign ramp = (rate == RATE_FAST) ? (AMP_W+1)'(prod >> HL_FAST)
                                              : (AMP_W+1)'(prod >> HL_SLOW);
        end
    endgenerate

    // Shift the ramp down by A (center) or 2A (down) to place the sweep.
    always_comb begin
        ramp_s = OFS_W'(ramp);
        base_s = (mode == SPREAD_DOWN) ? OFS_W'(span) : OFS_W'(amp);
        off_n  = ramp_s - base_s;
    end

    // Output register, forced to zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            offset_q <= '0;
        else if (!run)
            offset_q <= '0;
        else
            offset_q <= off_n;
    end
endmodule

// File: rtl/ssc_tri_gen.sv
`timescale 1ns/1ps
// ssc_tri_gen: triangular spread-spectrum offset generator (top).
// Assumes: the sample clock is steady; settings are applied at sweep minima.
module ssc_tri_gen import ssc_pkg::*; #(
    parameter int OFS_W    = 16,
    parameter int DEV_W    = 5,
    parameter int DEV_MAX  = 16,
    parameter int STEP_LSB = 82,
    parameter int HL_FAST  = 8,
    parameter int HL_SLOW  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    mode_down,
    input  logic                    rate_fast,
    input  logic [DEV_W-1:0]        dev_code,
    output logic signed [OFS_W-1:0] offset,
    output logic                    cycle_flag
);
    localparam int AMP_MAX  = DEV_MAX * STEP_LSB;
    localparam int AMP_W    = $clog2(AMP_MAX + 1);
    localparam int HL_MAX   = (HL_SLOW > HL_FAST) ? HL_SLOW : HL_FAST;
    localparam int HL_MIN   = (HL_SLOW > HL_FAST) ? HL_FAST : HL_SLOW;
    localparam int PW       = HL_MAX + 1;
    localparam int MAX_STEP = ((2 * AMP_MAX) >> HL_MIN) + 1;

    spread_mode_e      mode_q;
    mod_rate_e         rate_q;
    logic [AMP_W-1:0]  amp_q;
    logic [PW-1:0]     phase_nxt;
    logic              wrap_nxt;
    logic              load;
    logic              fast_sel;

    // Settings follow the inputs while idle and refresh at each minimum.
    assign load     = !en || wrap_nxt;
    assign fast_sel = en ? (rate_q == RATE_FAST) : rate_fast;

    ssc_cfg_reg #(
        .DEV_W(DEV_W), .DEV_MAX(DEV_MAX), .STEP_LSB(STEP_LSB), .AMP_W(AMP_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .mode_down(mode_down), .rate_fast(rate_fast), .dev_code(dev_code),
        .mode_q(mode_q), .rate_q(rate_q), .amp_q(amp_q)
    );

    ssc_phase_ctr #(
        .HL_FAST(HL_FAST), .HL_SLOW(HL_SLOW), .PW(PW)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .run(en), .fast_sel(fast_sel),
        .phase_nxt(phase_nxt), .wrap_nxt(wrap_nxt)
    );

    ssc_shaper #(
        .AMP_W(AMP_W), .PW(PW), .OFS_W(OFS_W), .HL_FAST(HL_FAST), .HL_SLOW(HL_SLOW)
    ) u_shape (
        .clk(clk), .rst_n(rst_n), .run(en), .phase_nxt(phase_nxt),
        .amp(amp_q), .mode(mode_q), .rate(rate_q), .offset_q(offset)
    );

    // Cycle-boundary flag, registered alongside the minimum sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cycle_flag <= 1'b0;
        else
            cycle_flag <= en && wrap_nxt;
    end
endmodule

// File: rtl/ssc_tri_chk.sv
`timescale 1ns/1ps
// ssc_tri_chk: property checker for ssc_tri_gen, attached by bind.
// Assumes: mode_q and amp_q are the generator's active settings.
module ssc_tri_chk #(
    parameter int OFS_W    = 16,
    parameter int AMP_W    = 11,
    parameter int MAX_STEP = 11
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic signed [OFS_W-1:0] offset,
    input logic                    cycle_flag,
    input logic                    mode_q,
    input logic [AMP_W-1:0]        amp_q
);
    logic             en_d, en_d2, mode_d, mode_d2;
    logic [AMP_W-1:0] amp_d, amp_d2;
    logic signed [OFS_W-1:0] off_d;
    int off_i, prev_i, amp_i, diff_i, min_i;

    // Delayed copies of the settings that produced the current output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d <= 1'b0; en_d2 <= 1'b0; mode_d <= 1'b0; mode_d2 <= 1'b0;
            amp_d <= '0; amp_d2 <= '0; off_d <= '0;
        end else begin
            en_d <= en; en_d2 <= en_d; mode_d <= mode_q; mode_d2 <= mode_d;
            amp_d <= amp_q; amp_d2 <= amp_d; off_d <= offset;
        end
    end

    // Integer views for the range and step comparisons.
    always_comb begin
        off_i  = int'(offset);
        prev_i = int'(off_d);
        amp_i  = int'(amp_d);
        diff_i = (off_i > prev_i) ? (off_i - prev_i) : (prev_i - off_i);
        min_i  = mode_d ? -2 * amp_i : -amp_i;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (offset == '0 && !cycle_flag)); // R2
    AST_FLAG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_flag |=> !cycle_flag); // R7
    AST_FLAG_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_flag |-> (en_d && off_i == min_i)); // R7
    AST_DOWN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (en_d && mode_d) |-> off_i <= 0); // R4
    AST_CENTER_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        (en_d && !mode_d) |-> (off_i <= amp_i && off_i >= -amp_i)); // R3
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_d && en_d2 && amp_d == amp_d2 && mode_d == mode_d2) |-> diff_i <= MAX_STEP); // R9
endmodule

bind ssc_tri_gen ssc_tri_chk #(
    .OFS_W(OFS_W), .AMP_W(AMP_W), .MAX_STEP(MAX_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .offset(offset),
    .cycle_flag(cycle_flag), .mode_q(mode_q), .amp_q(amp_q)
);

// File: tb/test_ssc_tri_gen.sv
`timescale 1ns/1ps
module test_ssc_tri_gen;
    localparam int DEV_W = 5;
    localparam int OFS_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic mode_down = 1'b0;
    logic rate_fast = 1'b0;
    logic [DEV_W-1:0] dev_code = '0;
    logic signed [OFS_W-1:0] offset;
    logic cycle_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ssc_tri_gen i_ssc_tri_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_down(mode_down),
        .rate_fast(rate_fast), .dev_code(dev_code),
        .offset(offset), .cycle_flag(cycle_flag)
    );

    typedef struct packed {
        logic [15:0] req;
        logic        down;
        logic        fast;
        logic [4:0]  dev;
        int          n;
        int          expv;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{"R2", 1'b0, 1'b1, 5'd8,     1,     5},
        '{"R3", 1'b0, 1'b1, 5'd8,   128,   656},
        '{"R3", 1'b0, 1'b1, 5'd8,   384,  -656},
        '{"R4", 1'b1, 1'b1, 5'd8,   128,     0},
        '{"R4", 1'b1, 1'b1, 5'd8,   384, -1312},
        '{"R6", 1'b0, 1'b0, 5'd16,  512,  1312},
        '{"R4", 1'b1, 1'b0, 5'd16, 1536, -2624},
        '{"R5", 1'b0, 1'b1, 5'd20,  128,  1312},
        '{"R5", 1'b0, 1'b1, 5'd0,   128,     0},
        '{"R4", 1'b1, 1'b1, 5'd3,   200,  -139},
        '{"R3", 1'b0, 1'b0, 5'd1,   100,    16}
    };

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic arm(input logic dn, input logic fs, input logic [4:0] dv);
        @(negedge clk);
        en = 1'b0; mode_down = dn; rate_fast = fs; dev_code = dv;
        repeat (2) @(posedge clk);
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Flag spacing, pulse width, value at the minimum and step size.
    task automatic flag_run(input logic fs, input int lim, input int e1, input int e2);
        int first = -1;
        int second = -1;
        int highs = 0;
        int maxd = 0;
        int prev = 0;
        arm(1'b0, fs, 5'd8);
        for (int c = 1; c <= lim; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (cycle_flag) begin
                highs++;
                if (first < 0) begin
                    first = c;
                    check("R7", int'(offset), -656);
                end else if (second < 0) begin
                    second = c;
                end
            end
            if (c > 1) begin
                if (int'(offset) - prev > maxd) maxd = int'(offset) - prev;
                if (prev - int'(offset) > maxd) maxd = prev - int'(offset);
            end
            prev = int'(offset);
        end
        check("R7", first, e1);
        check("R6", second, e2);
        check("R7", highs, 2);
        check("R9", (maxd <= 11) ? 1 : 0, 1);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(offset), 0);
        check("R1", int'(cycle_flag), 0);
        rst_n = 1'b1;
        edges(1);
        check("R1", int'(offset), 0);

        // Table walk: settings, edges after enable, expected offset
        for (int i = 0; i < NV; i++) begin
            arm(VECS[i].down, VECS[i].fast, VECS[i].dev);
            edges(VECS[i].n);
            check($sformatf("%s", VECS[i].req), int'(offset), VECS[i].expv);
        end

        // R6 R7 R9: flag timing at both rates
        flag_run(1'b1, 1000, 384, 896);
        flag_run(1'b0, 4000, 1536, 3584);

        // R8: settings changed mid-slope wait for the minimum
        arm(1'b0, 1'b1, 5'd8);
        edges(10);
        mode_down = 1'b1;
        dev_code = 5'd16;
        edges(118);
        check("R8", int'(offset), 656);
        edges(256);
        check("R8", int'(cycle_flag), 1);
        check("R8", int'(offset), -656);
        edges(128);
        check("R8", int'(offset), -1312);

        // R2: disable forces zero, re-enable restarts at the midpoint
        @(negedge clk);
        en = 1'b0;
        edges(1);
        check("R2", int'(offset), 0);
        check("R2", int'(cycle_flag), 0);
        mode_down = 1'b0;
        dev_code = 5'd8;
        edges(1);
        en = 1'b1;
        edges(1);
        check("R2", int'(offset), 5);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule